// File: doc/BRIEF.md
# Three-Level Space-Vector Dwell Time Calculator

This block turns one modulation request into the on-times of the three space vectors that surround the reference vector of a three-level inverter. Each request carries a modulation index, a phase angle and a switching period length in timer counts. The angle is reduced to one of six 60° areas and an angle local to that area. Every area is rotated back onto the first one, so one set of formulas serves all six. The block then multiplies by sine values taken from a 16-bit table and returns the zero-vector time, the times of the two active vectors, the area number and a code that says how the three phases rotate for that area.

Requests enter through a valid/ready handshake. The datapath is a fixed four-stage pipeline, and each accepted request produces exactly one result with a valid strobe. When the index is small, the block computes the times directly. When the index is in the upper part of the linear range, the block uses a double-amplitude substitution: it halves the index, computes the times, and doubles each time together with the period, so a result spans two switching periods.

Top module: `svpwm_dwell_calc`

## Requirements
- R1: `inReady` is high from the first clock after reset is released. A request is accepted on a clock edge where `inValid` and `inReady` are both high. Its result appears with `outValid` high after the fourth edge that follows. `outValid` is never high without such an accepted request.
- R2: While `rst_n` is low, `inReady`, `outValid` and every output field read zero.
- R3: `outArea` equals floor(6·`inAngle`/65536)+1, giving a value from 1 to 6. The angle word spans one full turn in 65536 steps.
- R4: `outRot` is 0 for areas 1 and 4, 1 for areas 2 and 5, and 2 for areas 3 and 6. These codes select the phase orders (a,b,c), (b,c,a) and (c,a,b).
- R5: The local angle θ is `inAngle` minus ceil(k·65536/6), where k is the area number minus 1. The index m is `inMod`/65536 and the period is P. `outFirst` is 2·m·P·sin(π/3−θ) and `outSecond` is 2·m·P·sin θ, each within 0.25 % of P plus 3 counts (twice that in double mode).
- R6: `outZero` is never negative. Each active time is clamped to what is left of the period, and the zero time takes the remainder. The three outputs therefore sum exactly to the effective period.
- R7: The threshold is 29688, which is 0.453 in 16-bit fraction. When `inMod` is above it, the block uses floor(`inMod`/2) as the index and doubles all three times, so the times are even and sum to 2·P. When `inMod` is at or below the threshold, the sum is P.
- R8: Two requests with the same index, period and local angle in different areas return identical times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can take a request |
| inAngle | input | 16 | Reference phase, full turn = 65536 |
| inMod | input | 16 | Modulation index, unsigned fraction of 65536 |
| inPeriod | input | 16 | Switching period in timer counts |
| outValid | output | 1 | Result strobe |
| outZero | output | 17 | Zero-vector time |
| outFirst | output | 17 | Time of the active vector at the start of the area |
| outSecond | output | 17 | Time of the active vector at the end of the area |
| outArea | output | 3 | Area number 1 to 6 |
| outRot | output | 2 | Phase rotation code |

## Verification
The bench aims at the angles one step either side of each area boundary. A compare against the wrong boundary, or a local angle taken from the wrong base, shows up there as an area number that is off by one or as times mirrored across the area. It drives the index exactly at the double-mode threshold and one count above it. An off-by-one in that comparison breaks the exact period sum and the even-value rule. Zero index, zero period and full-scale inputs check that the clamp and the remainder never wrap. Requests at the same local angle in all six areas expose any term that still depends on the area after folding.

// File: rtl/svpwm_dwell_pkg.sv
`timescale 1ns/1ps
package svpwm_dwell_pkg;

  // pipeline stage load strobes from control to datapath
  typedef struct packed {
    logic loadIn;
    logic loadSine;
    logic loadMul;
    logic loadOut;
  } stageStrobes_t;

  // first angle code of area k (k = 0..5): ceil(k * 2^w / 6)
  function automatic longint areaStart(input int k, input int w);
    longint fullTurn;
    fullTurn = longint'(1) <<< w;
    return (longint'(k) * fullTurn + 5) / 6;
  endfunction

  // sin(idx/steps * pi/2) in Q30 by odd power series
  function automatic longint sineQ30(input longint idx, input longint steps);
    longint x, x2, term, acc;
    x = (idx * 64'sd1686629713) / steps;
    x2 = (x * x) >>> 30;
    term = x;
    acc = x;
    for (int k = 1; k <= 8; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      acc = acc + term;
    end
    return acc;
  endfunction

  // table entry rounded to outBits of fraction, saturated to all ones
  function automatic longint sineEntry(input longint idx, input longint steps, input int outBits);
    longint raw, maxCode;
    maxCode = (longint'(1) <<< outBits) - 1;
    raw = (sineQ30(idx, steps) * (longint'(1) <<< outBits) + (longint'(1) <<< 29)) >>> 30;
    if (raw > maxCode) raw = maxCode;
    if (raw < 0) raw = 0;
    return raw;
  endfunction

endpackage

// File: rtl/svpwm_sine_rom.sv
`timescale 1ns/1ps
module svpwm_sine_rom #(
  parameter int ANGLE_W  = 16,
  parameter int SIN_W    = 16,
  parameter int LUT_BITS = 10,
  parameter int NPORTS   = 2
) (
  input  logic [NPORTS-1:0][ANGLE_W-1:0] phase,
  output logic [NPORTS-1:0][SIN_W-1:0]   value
);
  import svpwm_dwell_pkg::*;

  localparam int STEPS   = 1 << LUT_BITS;
  localparam int SHIFT   = ANGLE_W - 2 - LUT_BITS;
  localparam int IDX_W   = LUT_BITS + 1;
  localparam int EXT_W   = ANGLE_W + 1;
  localparam logic [EXT_W-1:0] QUARTER = EXT_W'(1) << (ANGLE_W - 2);
  localparam logic [EXT_W-1:0] HALF    = EXT_W'(1) << (ANGLE_W - 1);
  localparam logic [EXT_W-1:0] RND     = (SHIFT > 0) ? (EXT_W'(1) << (SHIFT - 1)) : '0;

  logic [SIN_W-1:0] sineTab [0:STEPS];

  // quarter wave, endpoints included
  for (genvar gi = 0; gi <= STEPS; gi++) begin : g_tab
    assign sineTab[gi] = SIN_W'(sineEntry(longint'(gi), longint'(STEPS), SIN_W));
  end

  // phase is expected within [0, half turn]
  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    logic [EXT_W-1:0] folded;
    logic [IDX_W-1:0] tabIdx;
    always_comb begin
      folded = EXT_W'(phase[gp]);
      if (folded > QUARTER) folded = HALF - folded;
      tabIdx = IDX_W'((folded + RND) >> SHIFT);
    end
    assign value[gp] = sineTab[tabIdx];
  end

endmodule

// File: rtl/svpwm_dwell_ctrl.sv
`timescale 1ns/1ps
module svpwm_dwell_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic inValid,
  output logic inReady,
  output logic outValid,
  output svpwm_dwell_pkg::stageStrobes_t strobes
);
  localparam int PIPE_STAGES = 4;

  logic                   readyReg;
  logic                   accept;
  logic [PIPE_STAGES-1:0] stageValid;

  assign accept = inValid && readyReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyReg   <= 1'b0;
      stageValid <= '0;
    end else begin
      readyReg   <= 1'b1;
      stageValid <= {stageValid[PIPE_STAGES-2:0], accept};
    end
  end

  assign inReady          = readyReg;
  assign strobes.loadIn   = accept;
  assign strobes.loadSine = stageValid[0];
  assign strobes.loadMul  = stageValid[1];
  assign strobes.loadOut  = stageValid[2];
  assign outValid         = stageValid[PIPE_STAGES-1];

endmodule

// File: rtl/svpwm_dwell_datapath.sv
`timescale 1ns/1ps
module svpwm_dwell_datapath #(
  parameter int ANGLE_W   = 16,
  parameter int MOD_W     = 16,
  parameter int PER_W     = 16,
  parameter int SIN_W     = 16,
  parameter int LUT_BITS  = 10,
  parameter int DBL_LIMIT = 29688
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  svpwm_dwell_pkg::stageStrobes_t strobes,
  input  logic [ANGLE_W-1:0]            inAngle,
  input  logic [MOD_W-1:0]              inMod,
  input  logic [PER_W-1:0]              inPeriod,
  output logic [PER_W:0]                outZero,
  output logic [PER_W:0]                outFirst,
  output logic [PER_W:0]                outSecond,
  output logic [2:0]                    outArea,
  output logic [1:0]                    outRot
);
  import svpwm_dwell_pkg::*;

  localparam int AREAS  = 6;
  localparam int TIME_W = PER_W + 1;
  localparam int MT_W   = MOD_W + PER_W;
  localparam int PROD_W = MT_W + SIN_W + 1;
  localparam int SCALE  = MOD_W + SIN_W - 1;
  localparam logic [PROD_W-1:0]  RND_PROD    = PROD_W'(1) << (SCALE - 1);
  localparam logic [ANGLE_W-1:0] SECTOR_SPAN = ANGLE_W'(areaStart(1, ANGLE_W));

  // stage 1: fold to area one, select index mode
  logic [2:0]         areaNext;
  logic [ANGLE_W-1:0] baseNext;
  logic               dblNext;

  always_comb begin
    areaNext = '0;
    baseNext = '0;
    for (int k = 1; k < AREAS; k++) begin
      if (inAngle >= ANGLE_W'(areaStart(k, ANGLE_W))) begin
        areaNext = 3'(k);
        baseNext = ANGLE_W'(areaStart(k, ANGLE_W));
      end
    end
  end

  assign dblNext = inMod > MOD_W'(DBL_LIMIT);

  logic [2:0]         s1Area;
  logic [ANGLE_W-1:0] s1Local;
  logic [MOD_W-1:0]   s1Mod;
  logic [PER_W-1:0]   s1Per;
  logic               s1Dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Area  <= '0;
      s1Local <= '0;
      s1Mod   <= '0;
      s1Per   <= '0;
      s1Dbl   <= 1'b0;
    end else if (strobes.loadIn) begin
      s1Area  <= areaNext;
      s1Local <= inAngle - baseNext;
      s1Mod   <= dblNext ? (inMod >> 1) : inMod;
      s1Per   <= inPeriod;
      s1Dbl   <= dblNext;
    end
  end

  // stage 2: sine lookups and index times period
  logic [1:0][ANGLE_W-1:0] romPhase;
  logic [1:0][SIN_W-1:0]   romValue;

  assign romPhase[0] = SECTOR_SPAN - s1Local;
  assign romPhase[1] = s1Local;

  svpwm_sine_rom #(
    .ANGLE_W (ANGLE_W),
    .SIN_W   (SIN_W),
    .LUT_BITS(LUT_BITS),
    .NPORTS  (2)
  ) sineRom (
    .phase(romPhase),
    .value(romValue)
  );

  logic [2:0]       s2Area;
  logic [PER_W-1:0] s2Per;
  logic             s2Dbl;
  logic [MT_W-1:0]  s2MTs;
  logic [SIN_W-1:0] s2SinFirst;
  logic [SIN_W-1:0] s2SinSecond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2Area      <= '0;
      s2Per       <= '0;
      s2Dbl       <= 1'b0;
      s2MTs       <= '0;
      s2SinFirst  <= '0;
      s2SinSecond <= '0;
    end else if (strobes.loadSine) begin
      s2Area      <= s1Area;
      s2Per       <= s1Per;
      s2Dbl       <= s1Dbl;
      s2MTs       <= MT_W'(s1Mod) * MT_W'(s1Per);
      s2SinFirst  <= romValue[0];
      s2SinSecond <= romValue[1];
    end
  end

  // stage 3: 2*m*Ts*sin with rounding
  logic [PROD_W-1:0] prodFirst;
  logic [PROD_W-1:0] prodSecond;

  assign prodFirst  = PROD_W'(s2MTs) * PROD_W'(s2SinFirst) + RND_PROD;
  assign prodSecond = PROD_W'(s2MTs) * PROD_W'(s2SinSecond) + RND_PROD;

  logic [2:0]        s3Area;
  logic [PER_W-1:0]  s3Per;
  logic              s3Dbl;
  logic [TIME_W-1:0] s3First;
  logic [TIME_W-1:0] s3Second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3Area   <= '0;
      s3Per    <= '0;
      s3Dbl    <= 1'b0;
      s3First  <= '0;
      s3Second <= '0;
    end else if (strobes.loadMul) begin
      s3Area   <= s2Area;
      s3Per    <= s2Per;
      s3Dbl    <= s2Dbl;
      s3First  <= TIME_W'(prodFirst >> SCALE);
      s3Second <= TIME_W'(prodSecond >> SCALE);
    end
  end

  // stage 4: clamp, remainder, optional doubling
  logic [PER_W-1:0] clampFirst;
  logic [PER_W-1:0] remain;
  logic [PER_W-1:0] clampSecond;
  logic [PER_W-1:0] zeroTime;
  logic [1:0]       rotNext;

  always_comb begin
    clampFirst  = (s3First > TIME_W'(s3Per)) ? s3Per : PER_W'(s3First);
    remain      = s3Per - clampFirst;
    clampSecond = (s3Second > TIME_W'(remain)) ? remain : PER_W'(s3Second);
    zeroTime    = remain - clampSecond;
    rotNext     = (s3Area >= 3'd3) ? 2'(s3Area - 3'd3) : 2'(s3Area);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outZero   <= '0;
      outFirst  <= '0;
      outSecond <= '0;
      outArea   <= '0;
      outRot    <= '0;
    end else if (strobes.loadOut) begin
      outZero   <= s3Dbl ? {zeroTime, 1'b0}    : {1'b0, zeroTime};
      outFirst  <= s3Dbl ? {clampFirst, 1'b0}  : {1'b0, clampFirst};
      outSecond <= s3Dbl ? {clampSecond, 1'b0} : {1'b0, clampSecond};
      outArea   <= s3Area + 3'd1;
      outRot    <= rotNext;
    end
  end

endmodule

// File: rtl/svpwm_dwell_calc.sv
`timescale 1ns/1ps
module svpwm_dwell_calc #(
  parameter int ANGLE_W   = 16,
  parameter int MOD_W     = 16,
  parameter int PER_W     = 16,
  parameter int SIN_W     = 16,
  parameter int LUT_BITS  = 10,
  parameter int DBL_LIMIT = 29688
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ANGLE_W-1:0] inAngle,
  input  logic [MOD_W-1:0]   inMod,
  input  logic [PER_W-1:0]   inPeriod,
  output logic               outValid,
  output logic [PER_W:0]     outZero,
  output logic [PER_W:0]     outFirst,
  output logic [PER_W:0]     outSecond,
  output logic [2:0]         outArea,
  output logic [1:0]         outRot
);
  svpwm_dwell_pkg::stageStrobes_t strobes;

  svpwm_dwell_ctrl ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  svpwm_dwell_datapath #(
    .ANGLE_W  (ANGLE_W),
    .MOD_W    (MOD_W),
    .PER_W    (PER_W),
    .SIN_W    (SIN_W),
    .LUT_BITS (LUT_BITS),
    .DBL_LIMIT(DBL_LIMIT)
  ) datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .inAngle  (inAngle),
    .inMod    (inMod),
    .inPeriod (inPeriod),
    .outZero  (outZero),
    .outFirst (outFirst),
    .outSecond(outSecond),
    .outArea  (outArea),
    .outRot   (outRot)
  );

endmodule

// File: rtl/svpwm_dwell_checker.sv
`timescale 1ns/1ps
module svpwm_dwell_checker #(
  parameter int ANGLE_W   = 16,
  parameter int MOD_W     = 16,
  parameter int PER_W     = 16,
  parameter int DBL_LIMIT = 29688
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               inReady,
  input logic [ANGLE_W-1:0] inAngle,
  input logic [MOD_W-1:0]   inMod,
  input logic [PER_W-1:0]   inPeriod,
  input logic               outValid,
  input logic [PER_W:0]     outZero,
  input logic [PER_W:0]     outFirst,
  input logic [PER_W:0]     outSecond,
  input logic [2:0]         outArea,
  input logic [1:0]         outRot
);
  localparam int TIME_W = PER_W + 1;
  localparam int SUM_W  = PER_W + 3;
  localparam int SCL_W  = ANGLE_W + 3;

  logic              accept;
  logic [SCL_W-1:0]  angleTimesSix;
  logic [2:0]        areaRef;
  logic [1:0]        rotRef;
  logic              dblRef;
  logic [SUM_W-1:0]  periodRef;
  logic [SUM_W-1:0]  timeSum;

  assign accept        = inValid && inReady;
  assign angleTimesSix = SCL_W'(inAngle) * SCL_W'(6);
  assign areaRef       = 3'(angleTimesSix >> ANGLE_W) + 3'd1;
  assign rotRef        = 2'((areaRef - 3'd1) % 3'd3);
  assign dblRef        = inMod > MOD_W'(DBL_LIMIT);
  assign periodRef     = dblRef ? (SUM_W'(inPeriod) << 1) : SUM_W'(inPeriod);
  assign timeSum       = SUM_W'(outZero) + SUM_W'(outFirst) + SUM_W'(outSecond);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##4 outValid);

  assert_no_orphan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(accept, 4));

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> inReady);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R2: assert (!outValid && !inReady && outZero == '0 &&
                                     outFirst == '0 && outSecond == '0);
    end
  end

  assert_area_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outArea == $past(areaRef, 4));

  assert_rot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outRot == $past(rotRef, 4));

  assert_period_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> timeSum == $past(periodRef, 4));

  assert_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(dblRef, 4)) |-> (!outZero[0] && !outFirst[0] && !outSecond[0]));

  logic unusedHigh;
  assign unusedHigh = ^{outZero[TIME_W-1], 1'b0};

endmodule

bind svpwm_dwell_calc svpwm_dwell_checker #(
  .ANGLE_W  (ANGLE_W),
  .MOD_W    (MOD_W),
  .PER_W    (PER_W),
  .DBL_LIMIT(DBL_LIMIT)
) checker_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .inAngle  (inAngle),
  .inMod    (inMod),
  .inPeriod (inPeriod),
  .outValid (outValid),
  .outZero  (outZero),
  .outFirst (outFirst),
  .outSecond(outSecond),
  .outArea  (outArea),
  .outRot   (outRot)
);

// File: tb/svpwm_dwell_calc_test.sv
`timescale 1ns/1ps
module svpwm_dwell_calc_test;
  localparam int  LIM   = 29688;
  localparam int  NMAX  = 2048;
  localparam real PI    = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inAngle = '0;
  logic [15:0] inMod = '0;
  logic [15:0] inPeriod = '0;
  logic        inReady;
  logic        outValid;
  logic [16:0] outZero, outFirst, outSecond;
  logic [2:0]  outArea;
  logic [1:0]  outRot;

  svpwm_dwell_calc uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inAngle(inAngle), .inMod(inMod), .inPeriod(inPeriod),
    .outValid(outValid), .outZero(outZero), .outFirst(outFirst),
    .outSecond(outSecond), .outArea(outArea), .outRot(outRot)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  int nSent = 0;
  int nRecv = 0;
  bit finished = 1'b0;
  int sAngle [0:NMAX-1];
  int sMod   [0:NMAX-1];
  int sPer   [0:NMAX-1];
  int sEdge  [0:NMAX-1];
  int rZero  [0:NMAX-1];
  int rFirst [0:NMAX-1];
  int rSecond[0:NMAX-1];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int areaBase(input int k);
    return (k * 65536 + 5) / 6;
  endfunction

  // result monitor
  always @(negedge clk) begin
    if (rst_n && outValid) begin : mon
      int i, a, m, p, expArea, loc, meff, mul, t0, t1, t2;
      real th, e1, e2, tol;
      i = nRecv;
      if (i >= nSent) begin
        check(1'b0, "R1", "result without request", i, nSent);
      end else begin
        a = sAngle[i]; m = sMod[i]; p = sPer[i];
        t0 = int'(outZero); t1 = int'(outFirst); t2 = int'(outSecond);
        expArea = (a * 6) / 65536 + 1;
        loc = a - areaBase(expArea - 1);
        th = loc * 2.0 * PI / 65536.0;
        mul = (m > LIM) ? 2 : 1;
        meff = (m > LIM) ? m / 2 : m;
        e1 = mul * 2.0 * meff / 65536.0 * p * $sin(PI / 3.0 - th);
        e2 = mul * 2.0 * meff / 65536.0 * p * $sin(th);
        tol = mul * (p * 0.0025 + 3.0);
        check(cyc == sEdge[i] + 3, "R1", "result cycle", cyc, sEdge[i] + 3);
        check(int'(outArea) == expArea, "R3", "area", int'(outArea), expArea);
        check(int'(outRot) == (expArea - 1) % 3, "R4", "rotation", int'(outRot), (expArea - 1) % 3);
        check((t1 - e1) <= tol && (e1 - t1) <= tol, "R5", "first time", t1, int'(e1));
        check((t2 - e2) <= tol && (e2 - t2) <= tol, "R5", "second time", t2, int'(e2));
        check(t0 + t1 + t2 == mul * p, "R6", "time sum", t0 + t1 + t2, mul * p);
        if (mul == 2)
          check(((t0 | t1 | t2) & 1) == 0, "R7", "doubled times even", (t0 | t1 | t2) & 1, 0);
        rZero[i] = t0; rFirst[i] = t1; rSecond[i] = t2;
      end
      nRecv++;
    end
  end

  task automatic send(input int a, input int m, input int p);
    int gap;
    gap = $urandom_range(0, 2);
    if (gap > 0) begin
      inValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    inValid  = 1'b1;
    inAngle  = 16'(a);
    inMod    = 16'(m);
    inPeriod = 16'(p);
    sAngle[nSent] = a; sMod[nSent] = m; sPer[nSent] = p;
    sEdge[nSent] = cyc + 1;
    nSent++;
    @(negedge clk);
  endtask

  task automatic drain();
    int waitCnt;
    inValid = 1'b0;
    waitCnt = 0;
    while (nRecv < nSent && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int foldStart;
    void'($urandom(32'd8675309));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(outValid == 1'b0, "R2", "outValid in reset", int'(outValid), 0);
    check(inReady == 1'b0, "R2", "inReady in reset", int'(inReady), 0);
    check(outZero == '0 && outFirst == '0 && outSecond == '0, "R2", "times in reset",
          int'(outZero | outFirst | outSecond), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1", "idle outValid", int'(outValid), 0);
    repeat (2) @(negedge clk);

    // corner cases
    send(0, 0, 1000);
    send(65535, 20000, 5000);
    for (int k = 1; k < 6; k++) begin
      send(areaBase(k) - 1, 25000, 40000);
      send(areaBase(k), 25000, 40000);
    end
    send(3000, LIM, 60000);      // R7 at threshold: direct
    send(3000, LIM + 1, 60000);  // R7 just above: doubled
    send(7000, 65535, 65535);
    send(5461, 59441, 65535);
    send(1234, 40000, 0);
    send(10922, 12000, 30000);
    drain();
    check(nRecv == nSent, "R1", "results after corners", nRecv, nSent);

    // R8 same local angle in all six areas
    foldStart = nSent;
    for (int k = 0; k < 6; k++) send(areaBase(k) + 1777, 23000, 50000);
    for (int k = 0; k < 6; k++) send(areaBase(k) + 4321, 47000, 52000);
    drain();
    for (int k = 1; k < 6; k++) begin
      check(rFirst[foldStart + k] == rFirst[foldStart], "R8", "folded first time",
            rFirst[foldStart + k], rFirst[foldStart]);
      check(rSecond[foldStart + k] == rSecond[foldStart], "R8", "folded second time",
            rSecond[foldStart + k], rSecond[foldStart]);
      check(rZero[foldStart + 6 + k] == rZero[foldStart + 6], "R8", "folded zero time doubled",
            rZero[foldStart + 6 + k], rZero[foldStart + 6]);
    end

    // constrained random
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)));
    end
    drain();
    check(nRecv == nSent, "R1", "one result per request", nRecv, nSent);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule